// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Select Control

This block sits between four bidirectional configuration pads of a clock generator and the rest of its control logic. While power-on reset is held, the pads are undriven, so board pull resistors set their levels. When reset is released, the block stores those levels once: three frequency-select bits and one pin-mode bit. It then enables the pad drivers so the same pads can carry clocks.

The block also receives the first configuration byte from the serial interface. From that byte and the stored straps it produces a registered 3-bit frequency code. The code comes from the straps unless the byte's override bit is set, in which case it comes from the byte's own 3-bit field. The block also registers the spread-spectrum controls and a global output-disable flag. The stored mode bit decides whether a shared pad is a stop-request input or a reference clock output.

Top module: `strap_cfg_top`

## Requirements
- R1: While `por_n` is low, `strap_valid`, `strap_oe`, `ref_oe`, `stop_in_sel`, `freq_sel`, `outputs_hiz`, `ss_en`, `ss_down` and `ss_wide` are all zero.
- R2: The pad bits are laid out as bit 0 = FS0, bit 1 = FS1, bit 2 = FS2 and bit 3 = MODE. Assume `por_n` rises between two clock edges and `SYNC_STAGES` = 2. Then `strap_valid` is still 0 after the second rising edge, and is 1 after the third. At that edge `strap_fs` takes `pad_in[2:0]` and `strap_mode` takes `pad_in[3]`.
- R3: Once `strap_valid` is 1, changes on `pad_in` leave `strap_fs` and `strap_mode` unchanged until `por_n` is asserted again.
- R4: `strap_oe` is 4'b1111 whenever `strap_valid` is 1 and `outputs_hiz` is 0. Otherwise it is 4'b0000.
- R5: One clock after `strap_valid` is seen high, and from then on, `freq_sel` equals the previous cycle's value of one of two sources. If `cfg_byte[3]` was 0, the source is `strap_fs`. If `cfg_byte[3]` was 1, the source is `cfg_byte[6:4]`.
- R6: `outputs_hiz` follows `cfg_byte[0]` with one clock of delay. While it is 1, `strap_oe` and `ref_oe` are both 0.
- R7: With `strap_valid` high, a latched MODE of 0 gives `stop_in_sel` = 1 and `ref_oe` = 0. A latched MODE of 1 gives `stop_in_sel` = 0 and `ref_oe` = !`outputs_hiz`.
- R8: Each spread control follows a bit of `cfg_byte` with one clock of delay: `ss_en` follows bit 1, `ss_down` follows bit 2 (1 = down spread, 0 = centre spread), and `ss_wide` follows bit 7 (1 = ±0.5 %, 0 = ±0.25 %).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_in | input | 4 | Raw levels of the four strap pads |
| cfg_byte | input | 8 | Serial configuration byte 0 |
| strap_oe | output | 4 | Output enables for the four strap pads |
| ref_oe | output | 1 | Output enable of the shared reference/stop pad |
| stop_in_sel | output | 1 | Shared pad acts as stop-request input |
| strap_valid | output | 1 | Straps have been captured |
| strap_fs | output | 3 | Latched frequency-select straps |
| strap_mode | output | 1 | Latched mode strap |
| freq_sel | output | 3 | Effective frequency code |
| outputs_hiz | output | 1 | All clock outputs to high impedance |
| ss_en | output | 1 | Spread spectrum enable |
| ss_down | output | 1 | Down spread (1) or centre spread (0) |
| ss_wide | output | 1 | Wide modulation depth |

## Verification
Two events can land in the same cycle. One is the override bit of the configuration byte changing, which moves the frequency source between the straps and the register field. The other is the strap pads toggling after capture, which must not disturb the stored bits. The bench provokes this by randomizing the pads on every cycle in which it writes a random configuration byte. For each such cycle it predicts `freq_sel` from the value it captured at reset release. A strap latch that reloaded, or a selector that read the live pads, would therefore show up as a mismatch. The global disable bit is also toggled in random bytes, and it is judged against the pad enables in the same sample.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W  = 3;
  localparam int CFG_W = 8;
  localparam int PAD_W = FS_W + 1;

  // configuration byte field positions
  localparam int CB_HIZ   = 0;
  localparam int CB_SSEN  = 1;
  localparam int CB_SSDN  = 2;
  localparam int CB_OVR   = 3;
  localparam int CB_FS_LO = 4;
  localparam int CB_DEPTH = 7;

  typedef struct packed {
    logic            mode;
    logic [FS_W-1:0] fs;
  } strap_t;

  typedef struct packed {
    logic            hiz;
    logic            ss_en;
    logic            ss_down;
    logic            ss_wide;
    logic [FS_W-1:0] fsel;
  } ctl_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAD_W-1:0] pad_in,
  output strap_t           strap_q,
  output logic             valid_q
);
  logic   cap_en;
  strap_t strap_d;

  always_comb begin
    cap_en  = ~valid_q;
    strap_d = strap_t'(pad_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      valid_q <= 1'b0;
    end else if (cap_en) begin
      strap_q <= strap_d;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_ctl.sv
module freq_ctl
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CFG_W-1:0] cfg_byte,
  input  strap_t           strap,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d.hiz     = cfg_byte[CB_HIZ];
    ctl_d.ss_en   = cfg_byte[CB_SSEN];
    ctl_d.ss_down = cfg_byte[CB_SSDN];
    ctl_d.ss_wide = cfg_byte[CB_DEPTH];
    ctl_d.fsel    = cfg_byte[CB_OVR] ? cfg_byte[CB_FS_LO +: FS_W] : strap.fs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (load_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [PAD_W-1:0] pad_in,
  input  logic [CFG_W-1:0] cfg_byte,
  output logic [PAD_W-1:0] strap_oe,
  output logic             ref_oe,
  output logic             stop_in_sel,
  output logic             strap_valid,
  output logic [FS_W-1:0]  strap_fs,
  output logic             strap_mode,
  output logic [FS_W-1:0]  freq_sel,
  output logic             outputs_hiz,
  output logic             ss_en,
  output logic             ss_down,
  output logic             ss_wide
);
  logic   rst_n_sync;
  strap_t strap_q;
  logic   valid_q;
  ctl_t   ctl_q;
  logic   drive_ok;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n_sync (rst_n_sync)
  );

  strap_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .pad_in  (pad_in),
    .strap_q (strap_q),
    .valid_q (valid_q)
  );

  freq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_en  (valid_q),
    .cfg_byte (cfg_byte),
    .strap    (strap_q),
    .ctl_q    (ctl_q)
  );

  assign drive_ok = valid_q & ~ctl_q.hiz;

  for (genvar i = 0; i < PAD_W; i++) begin : g_oe
    assign strap_oe[i] = drive_ok;
  end

  assign ref_oe      = drive_ok & strap_q.mode;
  assign stop_in_sel = valid_q & ~strap_q.mode;
  assign strap_valid = valid_q;
  assign strap_fs    = strap_q.fs;
  assign strap_mode  = strap_q.mode;
  assign freq_sel    = ctl_q.fsel;
  assign outputs_hiz = ctl_q.hiz;
  assign ss_en       = ctl_q.ss_en;
  assign ss_down     = ctl_q.ss_down;
  assign ss_wide     = ctl_q.ss_wide;
endmodule

// File: rtl/strap_chk.sv
module strap_chk (
  input logic       clk,
  input logic       por_n,
  input logic [3:0] pad_in,
  input logic [7:0] cfg_byte,
  input logic [3:0] strap_oe,
  input logic       ref_oe,
  input logic       stop_in_sel,
  input logic       strap_valid,
  input logic [2:0] strap_fs,
  input logic       strap_mode,
  input logic [2:0] freq_sel,
  input logic       outputs_hiz,
  input logic       ss_en,
  input logic       ss_down,
  input logic       ss_wide
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !por_n |-> (!strap_valid && strap_oe == 4'b0 && freq_sel == 3'b0 && !outputs_hiz)); // R1

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    strap_valid |=> ($stable(strap_fs) && $stable(strap_mode))); // R3

  AST_OE_GATED: assert property (@(posedge clk) disable iff (!por_n)
    (|strap_oe) |-> (strap_valid && !outputs_hiz)); // R4

  AST_FREQ_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    strap_valid |=> freq_sel == ($past(cfg_byte[3]) ? $past(cfg_byte[6:4]) : $past(strap_fs))); // R5

  AST_HIZ_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
    outputs_hiz |-> (strap_oe == 4'b0 && !ref_oe)); // R6

  AST_REF_MODE: assert property (@(posedge clk) disable iff (!por_n)
    ref_oe |-> (strap_mode && !stop_in_sel)); // R7

  AST_SPREAD_FOLLOW: assert property (@(posedge clk) disable iff (!por_n)
    strap_valid |=> (ss_en == $past(cfg_byte[1]) && ss_down == $past(cfg_byte[2])
                     && ss_wide == $past(cfg_byte[7]))); // R8
endmodule

bind strap_cfg_top strap_chk u_chk (.*);

// File: tb/strap_cfg_top_tb.sv
module strap_cfg_top_tb;
  logic       clk = 1'b0;
  logic       por_n;
  logic [3:0] pad_in;
  logic [7:0] cfg_byte;
  logic [3:0] strap_oe;
  logic       ref_oe, stop_in_sel, strap_valid, strap_mode;
  logic [2:0] strap_fs, freq_sel;
  logic       outputs_hiz, ss_en, ss_down, ss_wide;

  int total = 0;
  int bad   = 0;
  logic [3:0] cap;

  always #2.5 clk = ~clk;

  strap_cfg_top u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_fsel(input logic [7:0] b, input logic [3:0] s);
    return b[3] ? b[6:4] : s[2:0];
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reset_run(input logic [3:0] straps);
    @(negedge clk);
    por_n = 1'b0; pad_in = straps; cfg_byte = 8'h00;
    repeat (3) tick();
    chk("R1 valid", {7'b0, strap_valid}, 8'h00);
    chk("R1 oe", {3'b0, ref_oe, strap_oe}, 8'h00);
    chk("R1 stop", {7'b0, stop_in_sel}, 8'h00);
    chk("R1 ctl", {freq_sel, outputs_hiz, ss_en, ss_down, ss_wide, 1'b0}, 8'h00);
    @(negedge clk); por_n = 1'b1;
    tick(); tick();
    chk("R2 early", {7'b0, strap_valid}, 8'h00);
    tick();
    chk("R2 valid", {7'b0, strap_valid}, 8'h01);
    chk("R2 straps", {4'b0, strap_mode, strap_fs}, {4'b0, straps});
    chk("R4 oe", {4'b0, strap_oe}, 8'h0F);
    chk("R7 stop", {7'b0, stop_in_sel}, {7'b0, ~straps[3]});
    chk("R7 ref", {7'b0, ref_oe}, {7'b0, straps[3]});
    cap = straps;
    tick();
    chk("R5 strap source", {5'b0, freq_sel}, {5'b0, straps[2:0]});
  endtask

  task automatic apply_cfg(input logic [7:0] b, input logic [3:0] pads);
    logic hz;
    @(negedge clk);
    cfg_byte = b; pad_in = pads;
    tick();
    hz = b[0];
    chk("R5 freq", {5'b0, freq_sel}, {5'b0, exp_fsel(b, cap)});
    chk("R3 hold", {4'b0, strap_mode, strap_fs}, {4'b0, cap});
    chk("R6 hiz", {7'b0, outputs_hiz}, {7'b0, hz});
    chk("R4 oe", {4'b0, strap_oe}, hz ? 8'h00 : 8'h0F);
    chk("R7 ref", {6'b0, ref_oe, stop_in_sel}, {6'b0, cap[3] & ~hz, ~cap[3]});
    chk("R8 spread", {5'b0, ss_en, ss_down, ss_wide}, {5'b0, b[1], b[2], b[7]});
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] seeds [4];
    void'($urandom(32'h1f2e3d4c));
    por_n = 1'b0; pad_in = 4'h0; cfg_byte = 8'h00;
    seeds[0] = 4'h0; seeds[1] = 4'hF; seeds[2] = 4'hA; seeds[3] = 4'h5;
    for (int r = 0; r < 6; r++) begin
      reset_run(r < 4 ? seeds[r] : 4'($urandom()));
      // R3 directed: flip every pad after capture
      apply_cfg(8'h00, ~cap);
      // R5 override with field 000, then 111
      apply_cfg(8'h08, 4'($urandom()));
      apply_cfg(8'h78, 4'($urandom()));
      // R5 back to straps while field non-zero
      apply_cfg(8'h70, 4'($urandom()));
      // R6 hiz, R8 spread corners
      apply_cfg(8'h01, 4'($urandom()));
      apply_cfg(8'h86, 4'($urandom()));
      apply_cfg(8'h04, 4'($urandom()));
      for (int k = 0; k < 200; k++) apply_cfg(8'($urandom()), 4'($urandom()));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule